// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block sends PCM audio as a bus master over four serial data lines. All lanes share one bit clock and one word clock. The bit clock is divided down from the block's own clock by a programmable ratio. The word clock marks a left slot and a right slot, each 32 bit clocks long. Each lane takes left and right samples through valid/ready handshakes into one-entry holding registers. Each lane shifts its sample out MSB first inside a 32-bit slot. The sample can be 16, 20 or 24 bits wide and sits either at the high end or at the low end of the slot, with zero padding in the other bits.

Each lane has its own enable. Enable changes take effect only at a frame boundary, which is the start of a left slot. Lanes switched on together therefore start in the same frame and stay bit-aligned. A per-lane run flag shows when the lane has actually started or stopped. A flush input empties every holding register. A lane that is running but finds its holding register empty at a slot start sends a zero slot and raises a sticky underrun flag.

Top module: `audio_lane_tx`

## Requirements
- R1: While reset is high: bclk is 0, wclk is 1, every sdata line is 0, lane_run and underrun are all 0, and every left_ready and right_ready bit is 1.
- R2: The bit clock period in clk cycles is selected by div_code: 1 gives 2, 2 gives 4, 4 gives 8 and 6 gives 12. Any other code gives 2. bclk is high for exactly half of each period.
- R3: wclk is 0 during the 32 bit clocks of the left slot and 1 during the 32 bit clocks of the right slot. wclk and sdata change only in the clk cycle in which bclk falls.
- R4: Each slot is sent MSB first. width_code 0 selects 16-bit samples, 2 selects 20 bits and 3 selects 24 bits. The reserved code 1 is treated as 16 bits. The sample is taken from the low bits of the 24-bit input word, and the input bits above the selected width are ignored.
- R5: With msb_side = 1 the sample occupies slot bits 31 downward. With msb_side = 0 it occupies slot bits width-1 down to 0. All other slot bits are sent as 0.
- R6: Lane n uses bits [24n+23:24n] of left_data and right_data and drives sdata[n]. All lanes that are running transmit their slots in the same bit clocks.
- R7: lane_run[n] copies lane_en[n] only at the start of a left slot (the bit clock in which wclk falls). At every other time lane_run holds its value.
- R8: A lane whose lane_run is 0 drives sdata 0 and does not consume its held samples, so its ready bits stay 0 while a sample is held.
- R9: Each lane holds one left sample and one right sample. A ready bit is 1 when its register is empty. A sample is accepted in a cycle where valid and ready are both 1. The register is emptied when its slot starts on a running lane.
- R10: A buf_flush pulse empties both registers of every lane and clears every underrun flag, so all ready bits are 1 in the next cycle. buf_flush wins over a push in the same cycle.
- R11: A running lane that finds its register for a slot empty at that slot's start sends 32 zero bits and sets underrun[n]. underrun[n] stays set until buf_flush or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, divided down to make the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Bit clock divide code |
| width_code | input | 2 | Sample width code |
| msb_side | input | 1 | 1: sample at the high end of the slot, 0: at the low end |
| lane_en | input | 4 | Per-lane enable request |
| buf_flush | input | 1 | Empties all sample registers and clears the underrun flags |
| left_valid | input | 4 | Per-lane left sample valid |
| left_data | input | 96 | Left samples, 24 bits per lane |
| left_ready | output | 4 | Per-lane left register empty |
| right_valid | input | 4 | Per-lane right sample valid |
| right_data | input | 96 | Right samples, 24 bits per lane |
| right_ready | output | 4 | Per-lane right register empty |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock: 0 left, 1 right |
| sdata | output | 4 | Serial data, one line per lane |
| lane_run | output | 4 | Per-lane running status |
| underrun | output | 4 | Per-lane sticky underrun flag |

## Verification
The assertions check on every cycle the properties that need no knowledge of the data:
- serial data and word clock move only on a falling bit clock;
- run flags move only where the word clock falls;
- idle lanes stay silent;
- an accepted push fills its register;
- a flush empties every register;
- underrun flags stay set until flushed.

Only the bench scenarios can show the values that depend on the configuration:
- the bit clock period and duty for each divide code;
- the exact slot contents for each width and placement setting, on all lanes in the same frame;
- the one-frame lag of the run flags;
- the zero slots that an underrun sends.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int SLOT_W     = 32;
    localparam int SAMPLE_W   = 24;
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int HALF_W     = 4;
    localparam int CNT_W      = HALF_W + 1;
    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

    typedef enum logic [1:0] {
        WID_16  = 2'd0,
        WID_RSV = 2'd1,
        WID_20  = 2'd2,
        WID_24  = 2'd3
    } width_e;

    // One-cycle strobes from the bit timing generator
    typedef struct packed {
        logic tick;         // bit boundary: bclk falls, data advances
        logic slot_start;   // first bit of a slot
        logic frame_start;  // first bit of a left slot
        logic right;        // slot being started is the right one
    } strobe_t;

    // Half of the bit clock period, in clk cycles
    function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
        case (code)
            4'd2:    return 4'd2;
            4'd4:    return 4'd4;
            4'd6:    return 4'd6;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [5:0] sample_bits(input logic [1:0] code);
        case (width_e'(code))
            WID_20:  return 6'd20;
            WID_24:  return 6'd24;
            default: return 6'd16;
        endcase
    endfunction

    // Mask the sample to its width and place it in the slot
    function automatic logic [SLOT_W-1:0] place_sample(
        input logic [SAMPLE_W-1:0] s,
        input logic [1:0]          code,
        input logic                msb
    );
        logic [5:0]        w;
        logic [SLOT_W-1:0] mask;
        logic [SLOT_W-1:0] v;
        w    = sample_bits(code);
        mask = (SLOT_ONE << w) - SLOT_ONE;
        v    = {{(SLOT_W-SAMPLE_W){1'b0}}, s} & mask;
        return msb ? (v << (6'(SLOT_W) - w)) : v;
    endfunction
endpackage

// File: rtl/atx_bitclk.sv
module atx_bitclk import atx_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] div_code,
    output logic       bclk,
    output logic       wclk,
    output strobe_t    strb
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  last;
    logic [HALF_W-1:0] half;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_nx;

    always_comb begin
        half             = half_period(div_code);
        last             = {half, 1'b0} - CNT_W'(1);
        strb.tick        = (cnt >= last);
        cnt_nx           = strb.tick ? '0 : cnt + CNT_W'(1);
        idx_nx           = idx + IDX_W'(1);
        strb.slot_start  = strb.tick && (idx_nx[IDX_W-2:0] == '0);
        strb.frame_start = strb.tick && (idx_nx == '0);
        strb.right       = idx_nx[IDX_W-1];
    end

    // Bit index resets to the last right bit so the first tick opens a frame
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            idx  <= '1;
            bclk <= 1'b0;
            wclk <= 1'b1;
        end else begin
            cnt  <= cnt_nx;
            bclk <= (cnt_nx >= {1'b0, half});
            if (strb.tick) begin
                idx  <= idx_nx;
                wclk <= idx_nx[IDX_W-1];
            end
        end
    end
endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    logic accept;

    assign in_ready = !full;
    assign accept   = in_valid && !full && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end
        if (rst) begin
            data <= '0;
        end else if (accept) begin
            data <= in_data;
        end
    end
endmodule

// File: rtl/atx_lane.sv
module atx_lane import atx_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  strobe_t             strb,
    input  logic                en,
    input  logic                flush,
    input  logic [1:0]          width_code,
    input  logic                msb_side,
    input  logic                l_valid,
    input  logic [SAMPLE_W-1:0] l_data,
    output logic                l_ready,
    input  logic                r_valid,
    input  logic [SAMPLE_W-1:0] r_data,
    output logic                r_ready,
    output logic                sd,
    output logic                run,
    output logic                urun
);
    logic [1:0]          vld;
    logic [1:0]          rdy;
    logic [1:0]          full;
    logic [1:0]          take;
    logic [SAMPLE_W-1:0] din  [2];
    logic [SAMPLE_W-1:0] held [2];
    logic                run_nx;
    logic                side;
    logic                have;
    logic [SLOT_W-1:0]   shreg;

    assign vld     = {r_valid, l_valid};
    assign din[0]  = l_data;
    assign din[1]  = r_data;
    assign l_ready = rdy[0];
    assign r_ready = rdy[1];
    assign sd      = shreg[SLOT_W-1];

    always_comb begin
        run_nx     = strb.frame_start ? en : run;
        side       = strb.right;
        have       = full[side];
        take       = '0;
        take[side] = strb.slot_start && run_nx && have;
    end

    // index 0 holds the left sample, index 1 the right
    for (genvar s = 0; s < 2; s++) begin : g_side
        atx_hold #(.W(SAMPLE_W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .in_valid (vld[s]),
            .in_data  (din[s]),
            .in_ready (rdy[s]),
            .take     (take[s]),
            .full     (full[s]),
            .data     (held[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            shreg <= '0;
            urun  <= 1'b0;
        end else begin
            if (strb.frame_start) begin
                run <= en;
            end
            if (strb.slot_start) begin
                if (run_nx && have) begin
                    shreg <= place_sample(held[side], width_code, msb_side);
                end else begin
                    shreg <= '0;
                end
                if (run_nx && !have) begin
                    urun <= 1'b1;
                end
            end else if (strb.tick) begin
                shreg <= {shreg[SLOT_W-2:0], 1'b0};
            end
            if (flush) begin
                urun <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audio_lane_tx.sv
module audio_lane_tx import atx_pkg::*; #(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3:0]                div_code,
    input  logic [1:0]                width_code,
    input  logic                      msb_side,
    input  logic [LANES-1:0]          lane_en,
    input  logic                      buf_flush,
    input  logic [LANES-1:0]          left_valid,
    input  logic [LANES*SAMPLE_W-1:0] left_data,
    output logic [LANES-1:0]          left_ready,
    input  logic [LANES-1:0]          right_valid,
    input  logic [LANES*SAMPLE_W-1:0] right_data,
    output logic [LANES-1:0]          right_ready,
    output logic                      bclk,
    output logic                      wclk,
    output logic [LANES-1:0]          sdata,
    output logic [LANES-1:0]          lane_run,
    output logic [LANES-1:0]          underrun
);
    strobe_t strb;

    atx_bitclk u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .div_code (div_code),
        .bclk     (bclk),
        .wclk     (wclk),
        .strb     (strb)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        atx_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .strb       (strb),
            .en         (lane_en[n]),
            .flush      (buf_flush),
            .width_code (width_code),
            .msb_side   (msb_side),
            .l_valid    (left_valid[n]),
            .l_data     (left_data[n*SAMPLE_W +: SAMPLE_W]),
            .l_ready    (left_ready[n]),
            .r_valid    (right_valid[n]),
            .r_data     (right_data[n*SAMPLE_W +: SAMPLE_W]),
            .r_ready    (right_ready[n]),
            .sd         (sdata[n]),
            .run        (lane_run[n]),
            .urun       (underrun[n])
        );
    end
endmodule

// File: rtl/atx_chk.sv
module atx_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             buf_flush,
    input logic [LANES-1:0] left_valid,
    input logic [LANES-1:0] left_ready,
    input logic [LANES-1:0] right_ready,
    input logic             bclk,
    input logic             wclk,
    input logic [LANES-1:0] sdata,
    input logic [LANES-1:0] lane_run,
    input logic [LANES-1:0] underrun
);
    assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$fell(bclk) |-> $stable(sdata))
        else $error("sdata moved without a falling bit clock");

    assert_wclk_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$fell(bclk) |-> $stable(wclk))
        else $error("wclk moved without a falling bit clock");

    assert_run_at_frame_R7: assert property (@(posedge clk) disable iff (rst)
        !$fell(wclk) |-> $stable(lane_run))
        else $error("lane_run moved away from a frame boundary");

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        buf_flush |=> ((&left_ready) && (&right_ready)))
        else $error("a register stayed full after flush");

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            !lane_run[i] |-> !sdata[i])
            else $error("idle lane drives data");

        assert_push_fills_R9: assert property (@(posedge clk) disable iff (rst)
            (left_valid[i] && left_ready[i] && !buf_flush) |=> !left_ready[i])
            else $error("accepted left sample not held");

        assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            (underrun[i] && !buf_flush) |=> underrun[i])
            else $error("underrun flag dropped without flush");
    end
endmodule

bind audio_lane_tx atx_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .buf_flush   (buf_flush),
    .left_valid  (left_valid),
    .left_ready  (left_ready),
    .right_ready (right_ready),
    .bclk        (bclk),
    .wclk        (wclk),
    .sdata       (sdata),
    .lane_run    (lane_run),
    .underrun    (underrun)
);

// File: tb/audio_lane_tx_test.sv
`timescale 1ns/1ps
module audio_lane_tx_test;
    localparam int LANES = 4;
    localparam int DW    = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       div_code = 4'd1;
    logic [1:0]       width_code = 2'd0;
    logic             msb_side = 1'b1;
    logic [LANES-1:0] lane_en = '0;
    logic             buf_flush = 1'b0;
    logic [LANES-1:0] left_valid = '0;
    logic [LANES-1:0] right_valid = '0;
    logic [LANES*DW-1:0] left_data = '0;
    logic [LANES*DW-1:0] right_data = '0;
    logic [LANES-1:0] left_ready, right_ready, sdata, lane_run, underrun;
    logic             bclk, wclk;

    audio_lane_tx #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .div_code(div_code), .width_code(width_code),
        .msb_side(msb_side), .lane_en(lane_en), .buf_flush(buf_flush),
        .left_valid(left_valid), .left_data(left_data), .left_ready(left_ready),
        .right_valid(right_valid), .right_data(right_data), .right_ready(right_ready),
        .bclk(bclk), .wclk(wclk), .sdata(sdata), .lane_run(lane_run), .underrun(underrun)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0]  dc;
        logic [1:0]  wc;
        logic        msb;
        logic [23:0] base;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 2'd0, 1'b1, 24'h00A5C3},
        '{4'd2, 2'd2, 1'b1, 24'h0ABCDE},
        '{4'd4, 2'd3, 1'b0, 24'h5A5A5A},
        '{4'd6, 2'd2, 1'b0, 24'h0F0E1D},
        '{4'd1, 2'd1, 1'b1, 24'hC0FFEE},
        '{4'd3, 2'd3, 1'b1, 24'h9B3C71},
        '{4'd1, 2'd0, 1'b0, 24'hFF1234}
    };

    logic [63:0] frame [LANES];
    logic        wclk_ok;

    function automatic int exp_ratio(input logic [3:0] dc);
        case (dc)
            4'd1: return 2;
            4'd2: return 4;
            4'd4: return 8;
            4'd6: return 12;
            default: return 2;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input logic [23:0] s, input logic [1:0] wc, input logic msb);
        int w;
        logic [31:0] r;
        r = '0;
        w = (wc == 2'd2) ? 20 : (wc == 2'd3) ? 24 : 16;
        for (int k = 0; k < w; k++) begin
            if (msb) r[31-k] = s[w-1-k];
            else     r[k]    = s[k];
        end
        return r;
    endfunction

    function automatic logic [23:0] lane_left(input logic [23:0] base, input int ln);
        return base ^ (24'h030507 * 24'(ln));
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tk();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_brise();
        while (bclk !== 1'b0) tk();
        while (bclk !== 1'b1) tk();
    endtask

    task automatic sync_right();
        do wait_brise(); while (wclk !== 1'b0);
        do wait_brise(); while (wclk !== 1'b1);
    endtask

    task automatic grab_frame();
        wclk_ok = 1'b1;
        do wait_brise(); while (wclk !== 1'b0);
        for (int k = 0; k < 64; k++) begin
            if (k > 0) wait_brise();
            if (wclk !== (k >= 32)) wclk_ok = 1'b0;
            for (int ln = 0; ln < LANES; ln++) frame[ln][63-k] = sdata[ln];
        end
    endtask

    task automatic push_all(input logic [23:0] base);
        for (int ln = 0; ln < LANES; ln++) begin
            left_data[ln*DW +: DW]  = lane_left(base, ln);
            right_data[ln*DW +: DW] = ~lane_left(base, ln);
        end
        left_valid  = '1;
        right_valid = '1;
        tk();
        left_valid  = '0;
        right_valid = '0;
    endtask

    task automatic measure(output int per, output int hi);
        wait_brise();
        per = 0;
        hi  = 0;
        while (bclk === 1'b1) begin hi++; per++; tk(); end
        while (bclk === 1'b0) begin per++; tk(); end
    endtask

    task automatic flush_pulse();
        buf_flush = 1'b1;
        tk();
        buf_flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int per, hi, ex;
        logic [23:0] l;
        repeat (3) tk();
        // R1 reset state, observed while reset is held
        check("R1", "bclk", bclk, 0);
        check("R1", "wclk", wclk, 1);
        check("R1", "sdata", sdata, 0);
        check("R1", "lane_run", lane_run, 0);
        check("R1", "underrun", underrun, 0);
        check("R1", "ready", {left_ready, right_ready}, 8'hFF);
        rst = 1'b0;
        lane_en = '1;

        for (int v = 0; v < NV; v++) begin
            div_code   = VECS[v].dc;
            width_code = VECS[v].wc;
            msb_side   = VECS[v].msb;
            flush_pulse();
            wait_brise();
            measure(per, hi);
            ex = exp_ratio(VECS[v].dc);
            check("R2", "bclk period", per, ex);
            check("R2", "bclk high time", hi, ex / 2);
            sync_right();
            check("R9", "ready before push", {left_ready, right_ready}, 8'hFF);
            push_all(VECS[v].base);
            check("R9", "ready after push", {left_ready, right_ready}, 8'h00);
            grab_frame();
            check("R3", "wclk slot levels", wclk_ok, 1);
            for (int ln = 0; ln < LANES; ln++) begin
                l = lane_left(VECS[v].base, ln);
                check("R4 R5 R6", $sformatf("frame vec %0d lane %0d", v, ln), frame[ln],
                      {exp_word(l, VECS[v].wc, VECS[v].msb), exp_word(~l, VECS[v].wc, VECS[v].msb)});
            end
        end

        // Underrun behaviour
        div_code = 4'd1; width_code = 2'd0; msb_side = 1'b1;
        flush_pulse();
        check("R10", "underrun cleared by flush", underrun, 0);
        grab_frame();
        for (int ln = 0; ln < LANES; ln++)
            check("R11", $sformatf("zero frame lane %0d", ln), frame[ln], 0);
        check("R11", "underrun set", underrun, 4'hF);
        repeat (5) tk();
        check("R11", "underrun sticky", underrun, 4'hF);
        flush_pulse();
        check("R10", "underrun cleared again", underrun, 0);

        // Enable lag and idle lanes
        lane_en = '0;
        sync_right();
        do wait_brise(); while (wclk !== 1'b0);
        check("R7", "all lanes stopped", lane_run, 0);
        sync_right();
        lane_en = 4'b0101;
        tk();
        check("R7", "run lags enable", lane_run, 0);
        push_all(24'h13579B);
        grab_frame();
        check("R7", "run after frame start", lane_run, 4'b0101);
        for (int ln = 0; ln < LANES; ln++) begin
            l = lane_left(24'h13579B, ln);
            if (ln % 2 == 0)
                check("R6", $sformatf("enabled lane %0d", ln), frame[ln],
                      {exp_word(l, 2'd0, 1'b1), exp_word(~l, 2'd0, 1'b1)});
            else
                check("R8", $sformatf("idle lane %0d silent", ln), frame[ln], 0);
        end
        check("R8", "idle lanes keep samples", {left_ready, right_ready}, 8'b0101_0101);

        // Flush beats a same-cycle push
        left_data[DW +: DW] = 24'h00ABCD;
        left_valid = 4'b0010;
        buf_flush  = 1'b1;
        tk();
        left_valid = '0;
        buf_flush  = 1'b0;
        check("R10", "flush empties all", {left_ready, right_ready}, 8'hFF);

        // Disable lag
        sync_right();
        lane_en = '0;
        tk();
        check("R7", "run holds after disable", lane_run, 4'b0101);
        do wait_brise(); while (wclk !== 1'b0);
        check("R7", "run cleared at frame", lane_run, 0);
        check("R8", "stopped lanes silent", sdata, 0);

        finish_run();
    end
endmodule